// File: doc/BRIEF.md
# Four-mode serial port with multiprocessor address filtering

This block is a full-duplex serial port of the kind found beside small embedded controllers. Software drives it through an 8-bit register window with two addresses. One address holds the control and status register. The other is the data buffer: a write starts a transmission, and a read returns the last accepted received byte. A two-bit mode field selects one of four modes. Mode 00 is a synchronous shifter clocked from the core clock. Mode 01 is an asynchronous 8-bit frame at a variable rate. Mode 10 is an asynchronous 9-bit frame at a fixed rate. Mode 11 is an asynchronous 9-bit frame at a variable rate.

The variable-rate modes advance on `baud_tick`. This is a single-cycle pulse from an external timer at 16 times the bit rate. The fixed-rate 9-bit mode makes its own 16x tick from an internal divider. The asynchronous receiver oversamples the line, confirms the start bit at its midpoint and samples each bit near its centre. Data is sent and received LSB first.

A received byte is held in the buffer while the next frame is shifted in. The byte is offered to software only when the receive flag is clear. When the multiprocessor filter bit is set, frames that are not address frames (ninth bit 0) are dropped without disturbing software. In mode 01 the same bit drops frames that have a bad stop bit. The transmit and receive flags are also driven on two interrupt pins. The register window is a plain synchronous write with a combinational read. It has no back-pressure: a buffer write that arrives while a frame is still being sent is dropped.

Top module: `serport`

## Requirements
- R1: After reset, the control register reads 0x00, `txd` is 1, `rxd_oe` is 0, and both interrupt pins are 0.
- R2: `addr`=0 selects the control register and `addr`=1 selects the data buffer. The control bits are: [7:6] mode, [5] multiprocessor filter, [4] receive enable, [3] transmit ninth bit, [2] received ninth/stop bit, [1] transmit flag, [0] receive flag. A control write stores all eight bits, and a control read returns them.
- R3: An asynchronous frame on `txd` is a 0 start bit, then the buffer byte LSB first, then (in modes 10 and 11 only) the transmit ninth bit, then a 1 stop bit. Each bit lasts 16 sample ticks. In modes 01 and 11 the ticks are `baud_tick` pulses. In mode 10 there is one tick every FIX_SLOW clocks (64 clocks per bit), or every FIX_FAST clocks (32 clocks per bit) while `fast_fix` is 1.
- R4: The transmit flag rises at the start of the stop bit in the asynchronous modes and at the end of the eighth bit in mode 00. It falls only on a software control write. A buffer write made while a frame is in progress is ignored.
- R5: In the asynchronous modes the receiver samples `rxd_in` at bit centres and sets the receive flag in the middle of the stop bit. The received byte is then read at the buffer address. The control ninth bit captures the received ninth data bit in modes 10 and 11, and the stop bit in mode 01.
- R6: In modes 10 and 11 with the filter bit set, a frame whose ninth bit is 0 raises no flag and leaves the buffer unchanged. A frame whose ninth bit is 1 is accepted.
- R7: In mode 01 with the filter bit set, a frame whose stop bit is 0 is discarded. With the filter bit clear, the same frame is accepted and the control ninth bit reads 0.
- R8: While the receive enable bit is 0, no frame is received.
- R9: A frame that completes while the receive flag is still set is discarded, and the buffer keeps its value.
- R10: The buffer keeps the previous byte while the next frame is being received.
- R11: In mode 00 a buffer write shifts the byte out on `rxd_out` LSB first, with `rxd_oe` high. `txd` carries the shift clock: M0_PER clocks per bit, low for the first half and high for the second, and idle high. Data is stable at each rising edge.
- R12: In mode 00 reception starts when the receive enable bit is 1 and the receive flag is 0. `rxd_in` is sampled at each rising shift-clock edge, and the receive flag is set after the eighth bit. No new reception starts while the flag is set.
- R13: A low pulse on `rxd_in` shorter than half a bit is rejected as a false start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 1 | Register select: 0 control, 1 data buffer |
| wr | input | 1 | Write strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| baud_tick | input | 1 | 16x sample tick for the variable-rate modes |
| fast_fix | input | 1 | Selects the faster internal rate in mode 10 |
| rxd_in | input | 1 | Serial data line, input side |
| rxd_out | output | 1 | Serial data line, driven value in mode 00 transmit |
| rxd_oe | output | 1 | Output enable for the serial data line |
| txd | output | 1 | Asynchronous transmit line, or shift clock in mode 00 |
| irq_tx | output | 1 | Transmit flag |
| irq_rx | output | 1 | Receive flag |

## Verification
Transmission is driven with bytes whose bits alternate in different ways (0xA5, 0x3C, 0x5A, 0x96, 0xC3). These catch a reversed bit order, a dropped or doubled bit and a wrong ninth bit. Each mode is run at its own rate, so a wrong tick source or divider shows up as samples falling outside the bits. Received frames cover every case for the ninth bit and the stop bit, with the filter both on and off. They also cover a frame that arrives while the flag is still set, a frame sent with reception disabled, and a short low glitch. Together these tell apart the accept, discard and keep-buffer outcomes that a simple receiver would merge. A buffer read in the middle of the next frame separates true double buffering from a design that exposes its shifter.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int REGW = 8;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_BUF  = 1'b1;

  typedef enum logic [1:0] {
    MD_SHIFT  = 2'b00,
    MD_ASYNC8 = 2'b01,
    MD_FIX9   = 2'b10,
    MD_VAR9   = 2'b11
  } sp_mode_e;

  typedef enum logic [1:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP
  } rx_state_e;
endpackage

// File: rtl/serport_shift.sv
module serport_shift #(
  parameter int DW  = 8,
  parameter int PER = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_go,
  input  logic [DW-1:0] tx_data,
  input  logic          rx_go,
  input  logic          rxd_in,
  output logic          sclk,
  output logic          sd_out,
  output logic          sd_oe,
  output logic          busy,
  output logic          tx_done,
  output logic          rx_done,
  output logic [DW-1:0] rx_data
);
  localparam int HALF = PER / 2;
  localparam int PW   = $clog2(PER);
  localparam int BW   = $clog2(DW);
  localparam logic [PW-1:0] PH_LAST = PW'(PER - 1);
  localparam logic [PW-1:0] PH_MID  = PW'(HALF - 1);
  localparam logic [PW-1:0] PH_HI   = PW'(HALF);
  localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

  logic          busy_q, dir_q;
  logic [PW-1:0] ph_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sh_q;
  logic          wrap;

  assign wrap = busy_q && (ph_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      ph_q   <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else if (!busy_q) begin
      if (tx_go) begin
        busy_q <= 1'b1;
        dir_q  <= 1'b1;
        sh_q   <= tx_data;
        ph_q   <= '0;
        bit_q  <= '0;
      end else if (rx_go) begin
        busy_q <= 1'b1;
        dir_q  <= 1'b0;
        ph_q   <= '0;
        bit_q  <= '0;
      end
    end else begin
      ph_q <= wrap ? '0 : ph_q + 1'b1;
      if (!dir_q && ph_q == PH_MID) sh_q <= {rxd_in, sh_q[DW-1:1]};
      if (dir_q && wrap)            sh_q <= {1'b0, sh_q[DW-1:1]};
      if (wrap) begin
        if (bit_q == BIT_LAST) busy_q <= 1'b0;
        else                   bit_q  <= bit_q + 1'b1;
      end
    end
  end

  assign sclk    = !busy_q || (ph_q >= PH_HI);
  assign sd_out  = sh_q[0];
  assign sd_oe   = busy_q && dir_q;
  assign busy    = busy_q;
  assign tx_done = wrap && dir_q && (bit_q == BIT_LAST);
  assign rx_done = wrap && !dir_q && (bit_q == BIT_LAST);
  assign rx_data = sh_q;
endmodule

// File: rtl/serport_atx.sv
module serport_atx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          go,
  input  logic          nine,
  input  logic          b9,
  input  logic [DW-1:0] data,
  output logic          txd,
  output logic          busy,
  output logic          stop_start
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(FW + 1);
  localparam int KW = $clog2(OVS);
  localparam logic [KW-1:0] K_LAST = KW'(OVS - 1);

  logic          busy_q;
  logic [FW-1:0] sh_q;
  logic [KW-1:0] cnt_q;
  logic [CW-1:0] nb_q, last_q;
  logic          bit_end;

  assign bit_end = busy_q && tick && (cnt_q == K_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      nb_q   <= '0;
      last_q <= '0;
    end else if (!busy_q) begin
      if (go) begin
        busy_q <= 1'b1;
        sh_q   <= nine ? {1'b1, b9, data, 1'b0} : {2'b11, data, 1'b0};
        last_q <= nine ? CW'(FW) : CW'(FW - 1);
        cnt_q  <= '0;
        nb_q   <= '0;
      end
    end else if (bit_end) begin
      cnt_q <= '0;
      sh_q  <= {1'b1, sh_q[FW-1:1]};
      nb_q  <= nb_q + 1'b1;
      if (nb_q + 1'b1 == last_q) busy_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign txd        = !busy_q || sh_q[0];
  assign busy       = busy_q;
  assign stop_start = bit_end && (nb_q + CW'(2) == last_q);
endmodule

// File: rtl/serport_arx.sv
module serport_arx
  import serport_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  logic          nine,
  input  logic          rxd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit9,
  output logic          stop_ok
);
  localparam int KW = $clog2(OVS);
  localparam int BW = $clog2(DW + 1);
  localparam logic [KW-1:0] K_LAST = KW'(OVS - 1);
  localparam logic [KW-1:0] K_MID  = KW'(OVS / 2 - 1);

  rx_state_e     st_q;
  logic [1:0]    sync_q;
  logic          rxs;
  logic [KW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [DW:0]   sh_q;
  logic          stop_q, done_q;

  assign rxs = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      stop_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      done_q <= 1'b0;
      if (tick) begin
        unique case (st_q)
          RX_IDLE: if (en && !rxs) begin
            st_q  <= RX_START;
            cnt_q <= '0;
          end
          RX_START: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == K_MID) begin
              cnt_q <= '0;
              bit_q <= '0;
              st_q  <= rxs ? RX_IDLE : RX_DATA;
            end
          end
          RX_DATA: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == K_LAST) begin
              cnt_q <= '0;
              sh_q  <= {rxs, sh_q[DW:1]};
              bit_q <= bit_q + 1'b1;
              if (bit_q == (nine ? BW'(DW) : BW'(DW - 1))) st_q <= RX_STOP;
            end
          end
          RX_STOP: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == K_LAST) begin
              stop_q <= rxs;
              done_q <= 1'b1;
              st_q   <= RX_IDLE;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done    = done_q;
  assign data    = nine ? sh_q[DW-1:0] : sh_q[DW:1];
  assign bit9    = nine ? sh_q[DW] : stop_q;
  assign stop_ok = stop_q;
endmodule

// File: rtl/serport.sv
module serport
  import serport_pkg::*;
#(
  parameter int M0_PER   = 12,
  parameter int FIX_SLOW = 4,
  parameter int FIX_FAST = 2,
  parameter int OVS      = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            addr,
  input  logic            wr,
  input  logic [REGW-1:0] wdata,
  output logic [REGW-1:0] rdata,
  input  logic            baud_tick,
  input  logic            fast_fix,
  input  logic            rxd_in,
  output logic            rxd_out,
  output logic            rxd_oe,
  output logic            txd,
  output logic            irq_tx,
  output logic            irq_rx
);
  localparam int DVW = $clog2(FIX_SLOW + 1);

  sp_mode_e        mode_q;
  logic            mc_q, ren_q, tb8_q, rb8_q, ti_q, ri_q;
  logic [REGW-1:0] rbuf_q;
  logic [DVW-1:0]  dv_q;
  logic            fix_tick, samp_tick, is_shift, nine;
  logic            wr_ctrl, wr_buf;
  logic            sh_clk, sh_out, sh_oe, sh_busy, sh_txd, sh_rxd;
  logic [REGW-1:0] sh_data;
  logic            at_txd, at_busy, at_stop;
  logic            ar_done, ar_b9, ar_stop;
  logic [REGW-1:0] ar_data;
  logic            acc_async, acc_shift, ar_pass;

  assign is_shift = (mode_q == MD_SHIFT);
  assign nine     = mode_q[1];
  assign wr_ctrl  = wr && (addr == ADDR_CTRL);
  assign wr_buf   = wr && (addr == ADDR_BUF);

  // internal rate for the fixed 9-bit mode
  assign fix_tick = (dv_q >= (fast_fix ? DVW'(FIX_FAST - 1) : DVW'(FIX_SLOW - 1)));
  always_ff @(posedge clk) begin
    if (rst)           dv_q <= '0;
    else if (fix_tick) dv_q <= '0;
    else               dv_q <= dv_q + 1'b1;
  end
  assign samp_tick = (mode_q == MD_FIX9) ? fix_tick : baud_tick;

  serport_shift #(.DW(REGW), .PER(M0_PER)) u_shift (
    .clk(clk), .rst(rst),
    .tx_go(is_shift && wr_buf), .tx_data(wdata),
    .rx_go(is_shift && ren_q && !ri_q), .rxd_in(rxd_in),
    .sclk(sh_clk), .sd_out(sh_out), .sd_oe(sh_oe), .busy(sh_busy),
    .tx_done(sh_txd), .rx_done(sh_rxd), .rx_data(sh_data)
  );

  serport_atx #(.DW(REGW), .OVS(OVS)) u_atx (
    .clk(clk), .rst(rst), .tick(samp_tick),
    .go(!is_shift && wr_buf), .nine(nine), .b9(tb8_q), .data(wdata),
    .txd(at_txd), .busy(at_busy), .stop_start(at_stop)
  );

  serport_arx #(.DW(REGW), .OVS(OVS)) u_arx (
    .clk(clk), .rst(rst), .tick(samp_tick),
    .en(ren_q && !is_shift), .nine(nine), .rxd(rxd_in),
    .done(ar_done), .data(ar_data), .bit9(ar_b9), .stop_ok(ar_stop)
  );

  // multiprocessor filter: address bit in 9-bit modes, stop validity in 8-bit mode
  assign ar_pass   = !mc_q || ((mode_q == MD_ASYNC8) ? ar_stop : ar_b9);
  assign acc_async = ar_done && !is_shift && !ri_q && ar_pass;
  assign acc_shift = sh_rxd && is_shift && !ri_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_SHIFT;
      {mc_q, ren_q, tb8_q, rb8_q, ti_q, ri_q} <= '0;
      rbuf_q <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= sp_mode_e'(wdata[7:6]);
        {mc_q, ren_q, tb8_q, rb8_q, ti_q, ri_q} <= wdata[5:0];
      end
      if (sh_txd || at_stop) ti_q <= 1'b1;
      if (acc_async) begin
        rbuf_q <= ar_data;
        rb8_q  <= ar_b9;
        ri_q   <= 1'b1;
      end
      if (acc_shift) begin
        rbuf_q <= sh_data;
        ri_q   <= 1'b1;
      end
    end
  end

  assign rdata   = (addr == ADDR_CTRL) ? {mode_q, mc_q, ren_q, tb8_q, rb8_q, ti_q, ri_q} : rbuf_q;
  assign txd     = is_shift ? sh_clk : at_txd;
  assign rxd_out = sh_out;
  assign rxd_oe  = sh_oe;
  assign irq_tx  = ti_q;
  assign irq_rx  = ri_q;
endmodule

// File: rtl/serport_chk.sv
module serport_chk
  import serport_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            wr,
  input logic            addr,
  input logic            irq_tx,
  input logic            irq_rx,
  input logic            rxd_oe,
  input sp_mode_e        mode_q,
  input logic            mc_q,
  input logic            rb8_q,
  input logic [REGW-1:0] rbuf_q
);
  a_r4_ti_sw_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_tx) |-> $past(wr && addr == ADDR_CTRL));

  a_r5_ri_sw_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_rx) |-> $past(wr && addr == ADDR_CTRL));

  a_r9_buf_held: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_rx) && !$past(wr)) |-> $stable(rbuf_q));

  a_r6_addr_only: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_rx) && !$past(wr) && mc_q && mode_q[1]) |-> rb8_q);

  a_r11_drive_in_shift: assert property (@(posedge clk) disable iff (rst)
    rxd_oe |-> (mode_q == MD_SHIFT));
endmodule

bind serport serport_chk u_serport_chk (
  .clk(clk), .rst(rst), .wr(wr), .addr(addr),
  .irq_tx(irq_tx), .irq_rx(irq_rx), .rxd_oe(rxd_oe),
  .mode_q(mode_q), .mc_q(mc_q), .rb8_q(rb8_q), .rbuf_q(rbuf_q)
);

// File: tb/test_serport.sv
module test_serport;
  localparam int BITV = 32;  // variable-rate bit: 16 ticks, one tick every 2 clocks

  logic clk = 1'b0, rst = 1'b1;
  logic addr = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic baud_tick = 1'b0, fast_fix = 1'b0, rxd_in = 1'b1;
  logic rxd_out, rxd_oe, txd, irq_tx, irq_rx;
  int n_run = 0, n_fail = 0, cyc = 0, tk = 0;

  serport i_serport (
    .clk(clk), .rst(rst), .addr(addr), .wr(wr), .wdata(wdata), .rdata(rdata),
    .baud_tick(baud_tick), .fast_fix(fast_fix), .rxd_in(rxd_in),
    .rxd_out(rxd_out), .rxd_oe(rxd_oe), .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tk        <= (tk == 1) ? 0 : tk + 1;
    baud_tick <= (tk == 1);
    cyc       <= cyc + 1;
  end

  task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tg, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_ri(input int lim);
    for (int i = 0; i < lim && !irq_rx; i++) @(negedge clk);
  endtask

  task automatic cap_async(input int nb, input int bitc, output logic [8:0] got,
                           output logic st, output logic sp, output logic tip, output logic tim);
    got = '0;
    for (int g = 0; g < 5000 && txd === 1'b1; g++) @(negedge clk);
    repeat (bitc / 2) @(negedge clk);
    st = txd;
    for (int i = 0; i < nb; i++) begin
      repeat (bitc) @(negedge clk);
      got[i] = txd;
    end
    tip = irq_tx;
    repeat (bitc) @(negedge clk);
    sp = txd; tim = irq_tx;
  endtask

  task automatic send_async(input int nb, input logic [8:0] d, input logic stopv,
                            output logic ri_e, output logic ri_l);
    rxd_in = 1'b0;
    repeat (BITV) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd_in = d[i];
      repeat (BITV) @(negedge clk);
    end
    rxd_in = stopv;
    repeat (BITV / 4) @(negedge clk);
    ri_e = irq_rx;
    repeat (BITV / 2) @(negedge clk);
    ri_l = irq_rx;
    rxd_in = 1'b1;
    repeat (BITV) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd_reg(1'b0, v);
    chk("R1 ctrl after reset", v, 8'h00);
    chk("R1 lines after reset", {txd, rxd_oe, irq_tx, irq_rx}, 4'b1000);
    wr_reg(1'b0, 8'hAE);
    rd_reg(1'b0, v);
    chk("R2 ctrl readback", v, 8'hAE);
    wr_reg(1'b0, 8'h00);
    rd_reg(1'b0, v);
    chk("R2 ctrl cleared", v, 8'h00);
  endtask

  task automatic t_tx_mode1;
    logic [8:0] g; logic st, sp, tip, tim;
    wr_reg(1'b0, 8'h40);
    wr_reg(1'b1, 8'hA5);
    wr_reg(1'b1, 8'h00);  // while busy: must be ignored
    cap_async(8, BITV, g, st, sp, tip, tim);
    chk("R3 mode1 frame", {st, g[7:0], sp}, {1'b0, 8'hA5, 1'b1});
    chk("R4 busy write ignored", g[7:0], 8'hA5);
    chk("R4 ti low before stop", tip, 1'b0);
    chk("R4 ti high in stop", tim, 1'b1);
    repeat (3 * BITV) @(negedge clk);
    chk("R4 ti held", irq_tx, 1'b1);
    wr_reg(1'b0, 8'h40);
    chk("R4 ti cleared by write", irq_tx, 1'b0);
  endtask

  task automatic t_tx_nine;
    logic [8:0] g; logic st, sp, tip, tim;
    wr_reg(1'b0, 8'hC8);
    wr_reg(1'b1, 8'h3C);
    cap_async(9, BITV, g, st, sp, tip, tim);
    chk("R3 mode3 frame ninth=1", {st, g, sp}, {1'b0, 9'h13C, 1'b1});
    chk("R4 mode3 ti at stop", {tip, tim}, 2'b01);
    repeat (BITV) @(negedge clk);
    fast_fix = 1'b0;
    wr_reg(1'b0, 8'h80);
    wr_reg(1'b1, 8'h5A);
    cap_async(9, 64, g, st, sp, tip, tim);
    chk("R3 mode2 slow frame ninth=0", {st, g, sp}, {1'b0, 9'h05A, 1'b1});
    repeat (64) @(negedge clk);
    fast_fix = 1'b1;
    wr_reg(1'b0, 8'h80);
    wr_reg(1'b1, 8'h96);
    cap_async(9, 32, g, st, sp, tip, tim);
    chk("R3 mode2 fast frame", {st, g, sp}, {1'b0, 9'h096, 1'b1});
    repeat (64) @(negedge clk);
    fast_fix = 1'b0;
    wr_reg(1'b0, 8'h00);
  endtask

  task automatic t_rx_mode1;
    logic e, l; logic [7:0] v;
    wr_reg(1'b0, 8'h50);
    send_async(8, 9'h06B, 1'b1, e, l);
    chk("R5 ri not before mid stop", e, 1'b0);
    chk("R5 ri at mid stop", l, 1'b1);
    rd_reg(1'b1, v);
    chk("R5 received byte", v, 8'h6B);
    rd_reg(1'b0, v);
    chk("R5 stop bit captured", v[2], 1'b1);
    wr_reg(1'b0, 8'h50);
    rxd_in = 1'b0;
    repeat (8) @(negedge clk);
    rxd_in = 1'b1;
    repeat (3 * BITV) @(negedge clk);
    rd_reg(1'b1, v);
    chk("R13 glitch rejected", {irq_rx, v}, {1'b0, 8'h6B});
  endtask

  task automatic t_rx_buffering;
    logic e, l; logic [7:0] v, mid;
    fork
      send_async(8, 9'h012, 1'b1, e, l);
      begin
        repeat (BITV * 5) @(negedge clk);
        rd_reg(1'b1, mid);
      end
    join
    chk("R10 old byte during next frame", mid, 8'h6B);
    rd_reg(1'b1, v);
    chk("R10 new byte after frame", v, 8'h12);
    send_async(8, 9'h077, 1'b1, e, l);
    rd_reg(1'b1, v);
    chk("R9 overrun keeps buffer", {irq_rx, v}, {1'b1, 8'h12});
    wr_reg(1'b0, 8'h70);
    send_async(8, 9'h044, 1'b0, e, l);
    rd_reg(1'b1, v);
    chk("R7 filtered bad stop dropped", {irq_rx, v}, {1'b0, 8'h12});
    wr_reg(1'b0, 8'h50);
    send_async(8, 9'h055, 1'b0, e, l);
    rd_reg(1'b1, v);
    chk("R7 unfiltered bad stop kept", {irq_rx, v}, {1'b1, 8'h55});
    rd_reg(1'b0, v);
    chk("R7 stop bit reads 0", v[2], 1'b0);
  endtask

  task automatic t_rx_filter;
    logic e, l; logic [7:0] v;
    wr_reg(1'b0, 8'hF0);
    send_async(9, 9'h021, 1'b1, e, l);
    rd_reg(1'b1, v);
    chk("R6 data frame dropped", {irq_rx, v}, {1'b0, 8'h55});
    send_async(9, 9'h122, 1'b1, e, l);
    rd_reg(1'b1, v);
    chk("R6 address frame accepted", {irq_rx, v}, {1'b1, 8'h22});
    rd_reg(1'b0, v);
    chk("R5 ninth bit captured", v[2], 1'b1);
    wr_reg(1'b0, 8'h40);
    send_async(8, 9'h033, 1'b1, e, l);
    rd_reg(1'b1, v);
    chk("R8 disabled receiver", {irq_rx, v}, {1'b0, 8'h22});
  endtask

  task automatic t_shift_tx;
    logic [7:0] g; logic prev, oe_ok; int rises; int t0, t1;
    wr_reg(1'b0, 8'h00);
    g = '0; rises = 0; oe_ok = 1'b1; t0 = 0; t1 = 0;
    prev = 1'b1;
    wr_reg(1'b1, 8'hC3);
    for (int i = 0; i < 300 && rises < 8; i++) begin
      @(negedge clk);
      if (!prev && txd) begin
        g[rises] = rxd_out;
        oe_ok = oe_ok & rxd_oe;
        if (rises == 0) t0 = cyc;
        if (rises == 1) t1 = cyc;
        rises++;
      end
      prev = txd;
    end
    chk("R11 shifted byte", g, 8'hC3);
    chk("R11 line driven", oe_ok, 1'b1);
    chk("R11 clock period", t1 - t0, 12);
    chk("R4 mode0 ti not yet", irq_tx, 1'b0);
    repeat (8) @(negedge clk);
    chk("R4 mode0 ti after eighth bit", irq_tx, 1'b1);
    chk("R11 idle clock high, released", {txd, rxd_oe}, 2'b10);
    wr_reg(1'b0, 8'h00);
  endtask

  task automatic t_shift_rx;
    logic [7:0] d, v; logic hi;
    d = 8'h9D;
    rxd_in = d[0];
    fork
      begin
        for (int k = 0; k < 8; k++) begin
          @(negedge txd);
          rxd_in = d[k];
        end
      end
    join_none
    wr_reg(1'b0, 8'h10);
    wait_ri(300);
    chk("R12 ri after eighth bit", irq_rx, 1'b1);
    rd_reg(1'b1, v);
    chk("R12 received byte", v, 8'h9D);
    hi = 1'b1;
    repeat (30) begin
      @(negedge clk);
      hi = hi & txd;
    end
    chk("R12 no restart while ri set", hi, 1'b1);
    wr_reg(1'b0, 8'h00);
    rxd_in = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tx_mode1();
    t_tx_nine();
    t_rx_mode1();
    t_rx_buffering();
    t_rx_filter();
    t_shift_tx();
    t_shift_rx();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule